// File: doc/BRIEF.md
# Display Panel Command Interpreter

This block decodes the byte stream that a host sends to a small display panel over a full-duplex serial slave link. Every byte the host clocks in produces one reply byte. Each incoming byte is either the opcode of a new command or one of the parameter bytes that an earlier opcode asked for. The block keeps the panel's operating state: sleep, charge-pump booster, tearing-effect output, the three display modes (partial, normal, vertical scroll), colour inversion, display enable, a gamma curve index and a self-diagnosis byte.

Read opcodes do not answer in the byte that carries them. They fill a small reply buffer, and the host drains that buffer with the bytes it sends next, usually no-operation opcodes. A strobe marks each received byte. A select input frames a transaction, and dropping the select abandons any parameters still pending. An opcode the block does not support leaves all state untouched and raises a one-cycle error pulse.

Top module: `panel_cmd_ctrl`

## Requirements
- R1: After reset, sleep, normal mode and display enable are 1. Booster, tearing effect, partial mode, vertical scroll, inversion and gamma are 0. The self-diagnosis byte is 0xB0. The reply is 0x00, the reply buffer is empty and the error pulse is low.
- R2: For each byte accepted on a cycle with `byte_vld` high, `reply_o` shows the buffer entry at the read pointer from the next cycle on, and the pointer then advances. Once the pointer reaches the armed length, or moves past four entries, the reply is 0x00.
- R3: When no parameters are pending, an accepted byte is a new opcode. Otherwise it is a parameter and the pending count drops by one. Dropping `sel` clears the pending count. Strobes while `sel` is low are ignored.
- R4: The panel ID is the parameter `PANEL_ID` (0x838F03 by default). Opcode 0x04 arms its three bytes, most significant first. Opcodes 0xDA, 0xDB and 0xDC each arm one byte: high, middle and low.
- R5: Opcode 0x09 arms four bytes. Byte 0 is booster in bit 7. Byte 1 is 0x50 with partial in bit 2, sleep in bit 1 and normal in bit 0. Byte 2 has scroll in bit 7, invert in bit 5, display-on in bit 2, tearing in bit 1 and gamma bit 2 in bit 0. Byte 3 holds gamma bits 1:0 in bits 7:6.
- R6: Opcode 0x0A arms one byte: booster in bit 7, sleep in bits 6 and 4, partial in bit 5, normal in bit 3 and display-on in bit 2. Opcode 0x0C arms 0x05. Opcode 0x0E arms tearing in bit 7. Opcode 0x0F arms the self-diagnosis byte.
- R7: Opcode 0x10 sets sleep. Opcode 0x11 clears sleep and toggles self-diagnosis bit 6. The opcode pairs 0x02/0x03, 0x20/0x21 and 0x28/0x29 clear/set the booster, inversion and display enable.
- R8: Opcodes 0x12, 0x13 and 0x37 select partial, normal and vertical-scroll mode, and each clears the other two mode flags. Exactly one mode flag is set at all times.
- R9: Opcode 0x26 takes one parameter. Gamma becomes the index of the lowest set bit in the parameter's bits 3:0. A zero low nibble leaves gamma unchanged.
- R10: Opcode 0x35 takes one parameter and sets tearing once that parameter arrives. Opcode 0x34 clears tearing at once.
- R11: Opcodes 0xB0, 0xB1 and 0xC2 consume the next two bytes as parameters with no effect, even when those bytes equal valid opcodes.
- R12: Opcode 0xBD arms the two bytes 0x00 and 0x01. Every read opcode rewinds the read pointer to entry 0.
- R13: Opcode 0x01 restores every panel flag to its R1 value. The reply buffer is left as it was.
- R14: Opcodes 0x00 and 0xB4 are accepted with no effect. Any other opcode not listed here changes no state and drives `err_o` high for exactly the one cycle after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Transaction select, active high |
| byte_vld | input | 1 | One-cycle strobe: a byte has been received |
| byte_in | input | 8 | Received byte |
| reply_o | output | 8 | Reply byte for the latest accepted transfer |
| err_o | output | 1 | One-cycle pulse after an unsupported opcode |

## Verification
Directed sequences issue each read opcode after a known set of state changes and then drain the buffer with no-operation bytes. This separates the bit packing of the status bytes and tells a reply that is read too early from one read too late. Opcodes that take parameters are followed by bytes that are themselves valid opcodes, so a parameter that is wrongly decoded as a command shows up in a later status read. A select drop in the middle of a parameter sequence tells whether the count is really cleared. Random streams mix every supported opcode, arbitrary bytes and random deselects. A bench model follows them and predicts every reply byte and every error pulse.

// File: rtl/panel_cmd_pkg.sv
package panel_cmd_pkg;

   typedef struct packed {
      logic       sleep;
      logic       booster;
      logic       te;
      logic       partial;
      logic       normal;
      logic       vscr;
      logic       invert;
      logic       disp_on;
      logic [2:0] gamma;
      logic [7:0] diag;
   } pnl_flags_t;

   typedef enum logic [1:0] {
      PEND_NONE  = 2'd0,
      PEND_GAMMA = 2'd1,
      PEND_TE    = 2'd2
   } pnl_pend_e;

   localparam logic [7:0] DIAG_INIT = 8'hB0;

   function automatic pnl_flags_t flags_init();
      pnl_flags_t f;
      f         = '0;
      f.sleep   = 1'b1;
      f.normal  = 1'b1;
      f.disp_on = 1'b1;
      f.diag    = DIAG_INIT;
      return f;
   endfunction

   function automatic logic [2:0] low_bit_idx(input logic [3:0] nib);
      logic [2:0] idx;
      idx = 3'd0;
      for (int i = 3; i >= 0; i--) begin
         if (nib[i]) idx = 3'(i);
      end
      return idx;
   endfunction

endpackage

// File: rtl/pnl_cmd_decode.sv
module pnl_cmd_decode
   import panel_cmd_pkg::*;
#(
   parameter int          DEPTH    = 4,
   parameter logic [23:0] PANEL_ID = 24'h838F03,
   parameter int          LW       = $clog2(DEPTH + 1),
   parameter int          CW       = 2
) (
   input  logic [7:0]             op_i,
   input  pnl_flags_t             cur_i,
   output pnl_flags_t             nxt_o,
   output logic                   arm_o,
   output logic [LW-1:0]          arm_len_o,
   output logic [DEPTH-1:0][7:0]  arm_data_o,
   output logic [CW-1:0]          pcnt_o,
   output pnl_pend_e              pend_o,
   output logic                   bad_o
);

   if (DEPTH < 4) begin : g_depth_chk
      $error("pnl_cmd_decode: DEPTH must be at least 4");
   end
   if (CW < 2) begin : g_cw_chk
      $error("pnl_cmd_decode: CW must be at least 2");
   end

   always_comb begin
      nxt_o      = cur_i;
      arm_o      = 1'b0;
      arm_len_o  = '0;
      arm_data_o = '0;
      pcnt_o     = '0;
      pend_o     = PEND_NONE;
      bad_o      = 1'b0;
      case (op_i)
         8'h00, 8'hB4: ;
         8'h01: nxt_o = flags_init();
         8'h02: nxt_o.booster = 1'b0;
         8'h03: nxt_o.booster = 1'b1;
         8'h04: begin
            arm_o         = 1'b1;
            arm_len_o     = LW'(3);
            arm_data_o[0] = PANEL_ID[23:16];
            arm_data_o[1] = PANEL_ID[15:8];
            arm_data_o[2] = PANEL_ID[7:0];
         end
         8'h09: begin
            arm_o         = 1'b1;
            arm_len_o     = LW'(4);
            arm_data_o[0] = {cur_i.booster, 7'b0};
            arm_data_o[1] = {4'h5, 1'b0, cur_i.partial, cur_i.sleep, cur_i.normal};
            arm_data_o[2] = {cur_i.vscr, 1'b0, cur_i.invert, 2'b0,
                             cur_i.disp_on, cur_i.te, cur_i.gamma[2]};
            arm_data_o[3] = {cur_i.gamma[1:0], 6'b0};
         end
         8'h0A: begin
            arm_o         = 1'b1;
            arm_len_o     = LW'(1);
            arm_data_o[0] = {cur_i.booster, cur_i.sleep, cur_i.partial, cur_i.sleep,
                             cur_i.normal, cur_i.disp_on, 2'b0};
         end
         8'h0C: begin
            arm_o         = 1'b1;
            arm_len_o     = LW'(1);
            arm_data_o[0] = 8'h05;
         end
         8'h0E: begin
            arm_o         = 1'b1;
            arm_len_o     = LW'(1);
            arm_data_o[0] = {cur_i.te, 7'b0};
         end
         8'h0F: begin
            arm_o         = 1'b1;
            arm_len_o     = LW'(1);
            arm_data_o[0] = cur_i.diag;
         end
         8'h10: nxt_o.sleep = 1'b1;
         8'h11: begin
            nxt_o.sleep   = 1'b0;
            nxt_o.diag[6] = ~cur_i.diag[6];
         end
         8'h12: begin
            nxt_o.partial = 1'b1;
            nxt_o.normal  = 1'b0;
            nxt_o.vscr    = 1'b0;
         end
         8'h13: begin
            nxt_o.partial = 1'b0;
            nxt_o.normal  = 1'b1;
            nxt_o.vscr    = 1'b0;
         end
         8'h37: begin
            nxt_o.partial = 1'b0;
            nxt_o.normal  = 1'b0;
            nxt_o.vscr    = 1'b1;
         end
         8'h20: nxt_o.invert  = 1'b0;
         8'h21: nxt_o.invert  = 1'b1;
         8'h28: nxt_o.disp_on = 1'b0;
         8'h29: nxt_o.disp_on = 1'b1;
         8'h34: nxt_o.te      = 1'b0;
         8'h26: begin
            pcnt_o = CW'(1);
            pend_o = PEND_GAMMA;
         end
         8'h35: begin
            pcnt_o = CW'(1);
            pend_o = PEND_TE;
         end
         8'hB0, 8'hB1, 8'hC2: pcnt_o = CW'(2);
         8'hBD: begin
            arm_o         = 1'b1;
            arm_len_o     = LW'(2);
            arm_data_o[0] = 8'h00;
            arm_data_o[1] = 8'h01;
         end
         8'hDA, 8'hDB, 8'hDC: begin
            arm_o     = 1'b1;
            arm_len_o = LW'(1);
            case (op_i[1:0])
               2'b10:   arm_data_o[0] = PANEL_ID[23:16];
               2'b11:   arm_data_o[0] = PANEL_ID[15:8];
               default: arm_data_o[0] = PANEL_ID[7:0];
            endcase
         end
         default: bad_o = 1'b1;
      endcase
   end

endmodule

// File: rtl/pnl_panel_state.sv
module pnl_panel_state
   import panel_cmd_pkg::*;
#(
   parameter int          DEPTH    = 4,
   parameter logic [23:0] PANEL_ID = 24'h838F03,
   parameter int          LW       = $clog2(DEPTH + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sel_i,
   input  logic                  xfer_i,
   input  logic [7:0]            byte_i,
   output logic                  arm_o,
   output logic [LW-1:0]         arm_len_o,
   output logic [DEPTH-1:0][7:0] arm_data_o,
   output logic                  err_o
);

   localparam int CW = 2;

   pnl_flags_t    flags_q, dec_nxt;
   pnl_pend_e     pend_q, dec_pend;
   logic [CW-1:0] pcnt_q, dec_pcnt;
   logic          dec_arm, dec_bad, is_cmd;

   assign is_cmd = (pcnt_q == '0);

   pnl_cmd_decode #(.DEPTH(DEPTH), .PANEL_ID(PANEL_ID), .LW(LW), .CW(CW)) u_dec (
      .op_i       (byte_i),
      .cur_i      (flags_q),
      .nxt_o      (dec_nxt),
      .arm_o      (dec_arm),
      .arm_len_o  (arm_len_o),
      .arm_data_o (arm_data_o),
      .pcnt_o     (dec_pcnt),
      .pend_o     (dec_pend),
      .bad_o      (dec_bad)
   );

   assign arm_o = xfer_i & is_cmd & dec_arm;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= flags_init();
         pcnt_q  <= '0;
         pend_q  <= PEND_NONE;
         err_o   <= 1'b0;
      end else begin
         err_o <= 1'b0;
         if (!sel_i) begin
            pcnt_q <= '0;
         end else if (xfer_i) begin
            if (!is_cmd) begin
               pcnt_q <= pcnt_q - 1'b1;
               if (pcnt_q == CW'(1)) begin
                  case (pend_q)
                     PEND_GAMMA: if (|byte_i[3:0]) flags_q.gamma <= low_bit_idx(byte_i[3:0]);
                     PEND_TE:    flags_q.te <= 1'b1;
                     default:    ;
                  endcase
               end
            end else begin
               flags_q <= dec_nxt;
               pcnt_q  <= dec_pcnt;
               pend_q  <= dec_pend;
               err_o   <= dec_bad;
            end
         end
      end
   end

   AST_ONE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({flags_q.partial, flags_q.normal, flags_q.vscr}) == 1); // R8
   AST_DESEL_DROPS_PARAMS: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_i |=> pcnt_q == '0); // R3
   AST_ERR_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> $past(xfer_i)); // R14
   AST_ERR_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> flags_q == $past(flags_q)); // R14
   AST_SLEEP_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_i && is_cmd && byte_i == 8'h10) |=> flags_q.sleep); // R7

endmodule

// File: rtl/pnl_resp_buf.sv
module pnl_resp_buf #(
   parameter int DEPTH = 4,
   parameter int LW    = $clog2(DEPTH + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  xfer_i,
   input  logic                  arm_i,
   input  logic [LW-1:0]         arm_len_i,
   input  logic [DEPTH-1:0][7:0] arm_data_i,
   output logic [7:0]            reply_o
);

   localparam int            IW      = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [LW-1:0] PTR_END = LW'(DEPTH);

   if (LW < IW + 1) begin : g_lw_chk
      $error("pnl_resp_buf: LW too narrow for DEPTH");
   end

   logic [DEPTH-1:0][7:0] ent_q;
   logic [LW-1:0]         ptr_q, len_q;
   logic                  hit;
   logic [IW-1:0]         idx;

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     ent_q[g] <= '0;
         else if (arm_i) ent_q[g] <= arm_data_i[g];
      end
   end

   assign hit = (ptr_q < len_q);
   assign idx = ptr_q[IW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q   <= '0;
         len_q   <= '0;
         reply_o <= '0;
      end else if (xfer_i) begin
         reply_o <= hit ? ent_q[idx] : 8'h00;
         if (arm_i) begin
            ptr_q <= '0;
            len_q <= arm_len_i;
         end else if (ptr_q != PTR_END) begin
            ptr_q <= ptr_q + 1'b1;
         end
      end
   end

   AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_q <= PTR_END); // R2
   AST_DRAINED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_i && !hit) |=> reply_o == 8'h00); // R2
   AST_ARM_REWINDS: assert property (@(posedge clk) disable iff (!rst_n)
      arm_i |=> ptr_q == '0); // R12
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_i |=> $stable(reply_o)); // R2

endmodule

// File: rtl/panel_cmd_ctrl.sv
module panel_cmd_ctrl #(
   parameter int          RESP_DEPTH = 4,
   parameter logic [23:0] PANEL_ID   = 24'h838F03
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sel,
   input  logic       byte_vld,
   input  logic [7:0] byte_in,
   output logic [7:0] reply_o,
   output logic       err_o
);

   localparam int LW = $clog2(RESP_DEPTH + 1);

   logic                       xfer, arm;
   logic [LW-1:0]              arm_len;
   logic [RESP_DEPTH-1:0][7:0] arm_data;

   assign xfer = byte_vld & sel;

   pnl_panel_state #(.DEPTH(RESP_DEPTH), .PANEL_ID(PANEL_ID), .LW(LW)) u_state (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel_i      (sel),
      .xfer_i     (xfer),
      .byte_i     (byte_in),
      .arm_o      (arm),
      .arm_len_o  (arm_len),
      .arm_data_o (arm_data),
      .err_o      (err_o)
   );

   pnl_resp_buf #(.DEPTH(RESP_DEPTH), .LW(LW)) u_buf (
      .clk        (clk),
      .rst_n      (rst_n),
      .xfer_i     (xfer),
      .arm_i      (arm),
      .arm_len_i  (arm_len),
      .arm_data_i (arm_data),
      .reply_o    (reply_o)
   );

endmodule

// File: tb/tb_panel_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_panel_cmd_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sel = 1'b0;
   logic       byte_vld = 1'b0;
   logic [7:0] byte_in = 8'h00;
   logic [7:0] reply_o;
   logic       err_o;

   always #10 clk = ~clk;

   panel_cmd_ctrl dut (
      .clk(clk), .rst_n(rst_n), .sel(sel), .byte_vld(byte_vld),
      .byte_in(byte_in), .reply_o(reply_o), .err_o(err_o)
   );

   int n_chk = 0;
   int n_bad = 0;
   logic [7:0] last_reply;

   // bench reference state
   logic m_sleep, m_boost, m_te, m_part, m_norm, m_vscr, m_inv, m_on;
   logic [2:0] m_gamma;
   logic [7:0] m_diag;
   logic [7:0] m_buf [4];
   int m_len, m_ptr, m_pcnt;
   logic [7:0] m_cmd;

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic m_flags_reset();
      m_sleep = 1; m_norm = 1; m_on = 1;
      m_boost = 0; m_te = 0; m_part = 0; m_vscr = 0; m_inv = 0;
      m_gamma = 0; m_diag = 8'hB0;
   endtask

   function automatic logic [2:0] lowest(input logic [3:0] n);
      for (int i = 0; i < 4; i++) if (n[i]) return 3'(i);
      return 3'd0;
   endfunction

   task automatic arm(input int n, input logic [7:0] b0, input logic [7:0] b1,
                      input logic [7:0] b2, input logic [7:0] b3);
      m_buf[0] = b0; m_buf[1] = b1; m_buf[2] = b2; m_buf[3] = b3;
      m_len = n; m_ptr = 0;
   endtask

   task automatic model_step(input logic [7:0] b, output logic [7:0] er, output logic ee);
      er = (m_ptr < m_len) ? m_buf[m_ptr] : 8'h00;
      if (m_ptr < 4) m_ptr++;
      ee = 0;
      if (m_pcnt > 0) begin
         m_pcnt--;
         if (m_pcnt == 0) begin
            if (m_cmd == 8'h26 && b[3:0] != 0) m_gamma = lowest(b[3:0]);
            if (m_cmd == 8'h35) m_te = 1;
         end
      end else begin
         m_cmd = b;
         case (b)
            8'h00, 8'hB4: ;
            8'h01: m_flags_reset();
            8'h02: m_boost = 0;
            8'h03: m_boost = 1;
            8'h04: arm(3, 8'h83, 8'h8F, 8'h03, 0);
            8'h09: arm(4, {m_boost, 7'b0}, {4'h5, 1'b0, m_part, m_sleep, m_norm},
                       {m_vscr, 1'b0, m_inv, 2'b0, m_on, m_te, m_gamma[2]},
                       {m_gamma[1:0], 6'b0});
            8'h0A: arm(1, {m_boost, m_sleep, m_part, m_sleep, m_norm, m_on, 2'b0}, 0, 0, 0);
            8'h0C: arm(1, 8'h05, 0, 0, 0);
            8'h0E: arm(1, {m_te, 7'b0}, 0, 0, 0);
            8'h0F: arm(1, m_diag, 0, 0, 0);
            8'h10: m_sleep = 1;
            8'h11: begin m_sleep = 0; m_diag[6] = ~m_diag[6]; end
            8'h12: begin m_part = 1; m_norm = 0; m_vscr = 0; end
            8'h13: begin m_part = 0; m_norm = 1; m_vscr = 0; end
            8'h37: begin m_part = 0; m_norm = 0; m_vscr = 1; end
            8'h20: m_inv = 0;
            8'h21: m_inv = 1;
            8'h28: m_on = 0;
            8'h29: m_on = 1;
            8'h34: m_te = 0;
            8'h26, 8'h35: m_pcnt = 1;
            8'hB0, 8'hB1, 8'hC2: m_pcnt = 2;
            8'hBD: arm(2, 8'h00, 8'h01, 0, 0);
            8'hDA: arm(1, 8'h83, 0, 0, 0);
            8'hDB: arm(1, 8'h8F, 0, 0, 0);
            8'hDC: arm(1, 8'h03, 0, 0, 0);
            default: ee = 1;
         endcase
      end
   endtask

   task automatic xfer(input logic [7:0] b);
      logic [7:0] er;
      logic ee;
      model_step(b, er, ee);
      @(negedge clk);
      sel = 1; byte_vld = 1; byte_in = b;
      @(negedge clk);
      byte_vld = 0;
      last_reply = reply_o;
      chk("R2 reply", reply_o, er);
      chk("R14 error pulse", {7'b0, err_o}, {7'b0, ee});
   endtask

   task automatic deselect();
      @(negedge clk); sel = 0;
      @(negedge clk); sel = 1;
      m_pcnt = 0;
   endtask

   logic done = 0;

   initial begin : watchdog
      #(20 * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   localparam int NOPS = 24;
   logic [7:0] ops [NOPS] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h09, 8'h0A, 8'h0C,
                              8'h0E, 8'h0F, 8'h10, 8'h11, 8'h12, 8'h13, 8'h37, 8'h20,
                              8'h21, 8'h28, 8'h29, 8'h26, 8'h35, 8'hB0, 8'hBD, 8'hDB};

   initial begin : main
      int seed;
      logic [7:0] b;
      seed = 32'h5EED_0017;
      void'($urandom(seed));
      m_flags_reset();
      m_len = 0; m_ptr = 0; m_pcnt = 0; m_cmd = 0;
      for (int i = 0; i < 4; i++) m_buf[i] = 0;

      repeat (3) @(negedge clk);
      chk("R1 reply at reset", reply_o, 8'h00);
      chk("R1 err at reset", {7'b0, err_o}, 8'h00);
      rst_n = 1;
      sel = 1;

      // R1 / R5: status after reset
      xfer(8'h09);
      xfer(8'h00); chk("R5 byte0 reset", last_reply, 8'h00);
      xfer(8'h00); chk("R5 byte1 reset", last_reply, 8'h53);
      xfer(8'h00); chk("R5 byte2 reset", last_reply, 8'h04);
      xfer(8'h00); chk("R5 byte3 reset", last_reply, 8'h00);
      xfer(8'h00); chk("R2 past four", last_reply, 8'h00);
      xfer(8'h0F); xfer(8'h00); chk("R1 diag reset", last_reply, 8'hB0);
      xfer(8'h0A); xfer(8'h00); chk("R6 power byte reset", last_reply, 8'h5C);
      xfer(8'h00); chk("R2 past armed length", last_reply, 8'h00);
      xfer(8'h0C); xfer(8'h00); chk("R6 colour format", last_reply, 8'h05);

      // R4: identification
      xfer(8'h04);
      xfer(8'h00); chk("R4 id hi", last_reply, 8'h83);
      xfer(8'h00); chk("R4 id mid", last_reply, 8'h8F);
      xfer(8'h00); chk("R4 id lo", last_reply, 8'h03);
      xfer(8'hDA); xfer(8'h00); chk("R4 single hi", last_reply, 8'h83);
      xfer(8'hDB); xfer(8'h00); chk("R4 single mid", last_reply, 8'h8F);
      xfer(8'hDC); xfer(8'h00); chk("R4 single lo", last_reply, 8'h03);

      // R12: rewind mid-drain, 0xBD content
      xfer(8'h04); xfer(8'h00);
      xfer(8'hBD); chk("R12 reply before rewind", last_reply, 8'h8F);
      xfer(8'h00); chk("R12 bd byte0", last_reply, 8'h00);
      xfer(8'h00); chk("R12 bd byte1", last_reply, 8'h01);

      // R7: wake, booster, invert, display
      xfer(8'h11); xfer(8'h03); xfer(8'h21); xfer(8'h28);
      xfer(8'h0F); xfer(8'h00); chk("R7 diag bit6 toggled", last_reply, 8'hF0);
      xfer(8'h0A); xfer(8'h00); chk("R7 power byte", last_reply, 8'h88);

      // R9: gamma from lowest set bit; zero nibble ignored
      xfer(8'h26); xfer(8'hF8);
      xfer(8'h26); xfer(8'hF0);
      xfer(8'h09); xfer(8'h00); xfer(8'h00); xfer(8'h00);
      chk("R7 R9 byte2", last_reply, 8'h20);
      xfer(8'h00); chk("R9 gamma 3", last_reply, 8'hC0);

      // R10: tearing via parameter, then off
      xfer(8'h35); xfer(8'h10);
      xfer(8'h0E); xfer(8'h00); chk("R10 te set", last_reply, 8'h80);
      xfer(8'h34); xfer(8'h0E); xfer(8'h00); chk("R10 te cleared", last_reply, 8'h00);

      // R11: two swallowed parameters that look like opcodes
      xfer(8'hB1); xfer(8'h10); xfer(8'h29);
      xfer(8'h0A); xfer(8'h00); chk("R11 params ignored", last_reply, 8'h88);

      // R8: modes
      xfer(8'h37); xfer(8'h09); xfer(8'h00); xfer(8'h00);
      chk("R8 scroll clears normal", last_reply, 8'h50);
      xfer(8'h00); chk("R8 scroll bit", last_reply, 8'hA0);
      xfer(8'h12); xfer(8'h0A); xfer(8'h00); chk("R8 partial", last_reply, 8'hA0);

      // R3: deselect abandons pending parameter
      xfer(8'h26); deselect(); xfer(8'h10);
      xfer(8'h0A); xfer(8'h00); chk("R3 byte after deselect is opcode", last_reply, 8'hF0);
      @(negedge clk); sel = 0; byte_vld = 1; byte_in = 8'h11;
      @(negedge clk); byte_vld = 0; sel = 1;
      xfer(8'h0A); xfer(8'h00); chk("R3 deselected strobe ignored", last_reply, 8'hF0);

      // R14: unsupported opcode
      xfer(8'h2A); chk("R14 err raised", {7'b0, err_o}, 8'h01);
      @(negedge clk); chk("R14 err one cycle", {7'b0, err_o}, 8'h00);
      xfer(8'h0A); xfer(8'h00); chk("R14 state kept", last_reply, 8'hF0);
      xfer(8'hB4); xfer(8'h00);

      // R13: software reset
      xfer(8'h01); xfer(8'h09); xfer(8'h00); xfer(8'h00);
      chk("R13 soft reset byte1", last_reply, 8'h53);
      xfer(8'h00); chk("R13 soft reset byte2", last_reply, 8'h04);

      // random mix against the bench model
      for (int i = 0; i < 3000; i++) begin
         if ($urandom_range(0, 3) == 0) b = 8'($urandom_range(0, 255));
         else b = ops[$urandom_range(0, NOPS - 1)];
         if ($urandom_range(0, 40) == 0) deselect();
         xfer(b);
      end

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule